// File: doc/BRIEF.md
# Dual-Port Hardware Lock Bank

This block holds a bank of single-bit locks that two processor ports share. Each lock sits at its own index. When a port reads an index, it makes an atomic test-and-set attempt on that lock. The returned word tells the port whether it now owns the lock. When a port writes an index, the lock is released, whatever the bus carries. Software spins on reads until a claim succeeds. It uses the lock to guard a short critical section and then writes the same index to let the lock go.

Both ports can act in the same clock cycle. Releases from either port take effect before any claim in that cycle. When both ports claim the same lock at once, port 0 has the higher priority. A 32-bit status vector always shows which locks are held, and observing it never changes the lock state. The claim result for a read is registered and appears in the cycle after the read strobe.

Top module: `spin_lock_bank`

## Requirements
- R1: After reset every lock is free, `held_o` is all zeros, and both read-data outputs are zero.
- R2: A read strobe on a free lock claims it. In the next cycle the port's read data is 1 (value 32'h1), and bit `idx` of `held_o` is 1.
- R3: A read strobe on a lock that is held and not released in the same cycle returns 0 in the next cycle, and the lock state stays unchanged.
- R4: A write strobe releases the addressed lock, so bit `idx` of `held_o` is 0 in the next cycle. A write to a lock that is already free has no effect on any lock.
- R5: When both ports claim the same free lock in one cycle, port 0 reads 1 and port 1 reads 0, and the lock ends up held.
- R6: When both ports claim different free locks in one cycle, both claims succeed.
- R7: If one port releases a lock in the same cycle in which the other port (or the same port) claims it, the release is applied first and the claim succeeds.
- R8: `held_o` bit i is 1 exactly when lock i is held. The status vector is a plain output, and no activity on it changes the state.
- R9: A port's read data is 0 in any cycle that follows a cycle in which that port had no read strobe.
- R10: Operations on one index change only that index's bit of `held_o`. This holds at both ends of the index range (0 and 31) as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_rd_i | input | 1 | Port 0 read strobe: claim attempt |
| p0_wr_i | input | 1 | Port 0 write strobe: release |
| p0_idx_i | input | 5 | Port 0 lock index |
| p0_rdata_o | output | 32 | Port 0 claim result, one cycle after the read |
| p1_rd_i | input | 1 | Port 1 read strobe: claim attempt |
| p1_wr_i | input | 1 | Port 1 write strobe: release |
| p1_idx_i | input | 5 | Port 1 lock index |
| p1_rdata_o | output | 32 | Port 1 claim result, one cycle after the read |
| held_o | output | 32 | Current state of all locks, 1 = held |

## Verification
Directed patterns come first. A lone claim, a repeat claim and a cross-port claim on one index separate the test-and-set behaviour from a plain read. Simultaneous claims of one index are contrasted with simultaneous claims of different indices. This tells the fixed priority apart from a global one-winner rule. Same-cycle release-and-claim pairs, in both port directions, confirm that releases are ordered ahead of claims. A dense random phase then confines the indices to a handful of values so that contention is frequent. Every cycle is compared against a sequential behavioural model, including the boundary indices 0 and 31.

// File: rtl/lock_pkg.sv
package lock_pkg;

    // Per-port operation derived from the two strobes.
    typedef enum logic [1:0] {
        OP_IDLE       = 2'b00,
        OP_CLAIM      = 2'b01,
        OP_FREE       = 2'b10,
        OP_FREE_CLAIM = 2'b11
    } lock_op_e;

    function automatic lock_op_e op_of(input logic rd, input logic wr);
        lock_op_e op;
        unique case ({wr, rd})
            2'b01:   op = OP_CLAIM;
            2'b10:   op = OP_FREE;
            2'b11:   op = OP_FREE_CLAIM;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

    function automatic logic op_claims(input lock_op_e op);
        return (op == OP_CLAIM) || (op == OP_FREE_CLAIM);
    endfunction

    function automatic logic op_frees(input lock_op_e op);
        return (op == OP_FREE) || (op == OP_FREE_CLAIM);
    endfunction

endpackage

// File: rtl/lock_decode.sv
// Turns an enabled index into a one-hot lock mask.
module lock_decode #(
    parameter int NUM_LOCKS = 32,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic                 en_i,
    input  logic [IDX_W-1:0]     idx_i,
    output logic [NUM_LOCKS-1:0] mask_o
);

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_bit
        assign mask_o[g] = en_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/lock_arbiter.sv
// Resolves claims against the post-release state with port 0 first.
module lock_arbiter #(
    parameter int NUM_LOCKS = 32
) (
    input  logic [NUM_LOCKS-1:0] held_i,
    input  logic [NUM_LOCKS-1:0] free_mask_i,
    input  logic [NUM_LOCKS-1:0] claim0_i,
    input  logic [NUM_LOCKS-1:0] claim1_i,
    output logic [NUM_LOCKS-1:0] held_next_o,
    output logic                 grant0_o,
    output logic                 grant1_o
);

    logic [NUM_LOCKS-1:0] after_free;
    logic [NUM_LOCKS-1:0] win0;
    logic [NUM_LOCKS-1:0] win1;

    for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
        assign after_free[g] = held_i[g] && !free_mask_i[g];
        assign win0[g]       = claim0_i[g] && !after_free[g];
        assign win1[g]       = claim1_i[g] && !after_free[g] && !claim0_i[g];
    end

    assign held_next_o = after_free | win0 | win1;
    assign grant0_o    = |win0;
    assign grant1_o    = |win1;

endmodule

// File: rtl/spin_lock_bank.sv
module spin_lock_bank #(
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 p0_rd_i,
    input  logic                 p0_wr_i,
    input  logic [IDX_W-1:0]     p0_idx_i,
    output logic [DATA_W-1:0]    p0_rdata_o,
    input  logic                 p1_rd_i,
    input  logic                 p1_wr_i,
    input  logic [IDX_W-1:0]     p1_idx_i,
    output logic [DATA_W-1:0]    p1_rdata_o,
    output logic [NUM_LOCKS-1:0] held_o
);
    import lock_pkg::*;

    typedef struct packed {
        logic [NUM_LOCKS-1:0] held;
        logic [DATA_W-1:0]    rdata0;
        logic [DATA_W-1:0]    rdata1;
    } bank_state_t;

    bank_state_t st_d, st_q;

    lock_op_e op0, op1;
    logic [NUM_LOCKS-1:0] free0_mask, free1_mask;
    logic [NUM_LOCKS-1:0] claim0_mask, claim1_mask;
    logic [NUM_LOCKS-1:0] held_next;
    logic                 grant0, grant1;

    assign op0 = op_of(p0_rd_i, p0_wr_i);
    assign op1 = op_of(p1_rd_i, p1_wr_i);

    lock_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec_free0 (
        .en_i(op_frees(op0)), .idx_i(p0_idx_i), .mask_o(free0_mask));
    lock_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec_free1 (
        .en_i(op_frees(op1)), .idx_i(p1_idx_i), .mask_o(free1_mask));
    lock_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec_claim0 (
        .en_i(op_claims(op0)), .idx_i(p0_idx_i), .mask_o(claim0_mask));
    lock_decode #(.NUM_LOCKS(NUM_LOCKS)) u_dec_claim1 (
        .en_i(op_claims(op1)), .idx_i(p1_idx_i), .mask_o(claim1_mask));

    lock_arbiter #(.NUM_LOCKS(NUM_LOCKS)) u_arb (
        .held_i      (st_q.held),
        .free_mask_i (free0_mask | free1_mask),
        .claim0_i    (claim0_mask),
        .claim1_i    (claim1_mask),
        .held_next_o (held_next),
        .grant0_o    (grant0),
        .grant1_o    (grant1)
    );

    always_comb begin
        st_d        = st_q;
        st_d.held   = held_next;
        st_d.rdata0 = {{(DATA_W-1){1'b0}}, grant0};
        st_d.rdata1 = {{(DATA_W-1){1'b0}}, grant1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p0_rdata_o = st_q.rdata0;
    assign p1_rdata_o = st_q.rdata1;
    assign held_o     = st_q.held;

endmodule

// File: rtl/spin_lock_bank_chk.sv
module spin_lock_bank_chk #(
    parameter int NUM_LOCKS = 32,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LOCKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 p0_rd_i,
    input logic                 p0_wr_i,
    input logic [IDX_W-1:0]     p0_idx_i,
    input logic [DATA_W-1:0]    p0_rdata_o,
    input logic                 p1_rd_i,
    input logic                 p1_wr_i,
    input logic [IDX_W-1:0]     p1_idx_i,
    input logic [DATA_W-1:0]    p1_rdata_o,
    input logic [NUM_LOCKS-1:0] held_o
);
    logic same_idx;
    assign same_idx = (p0_idx_i == p1_idx_i);

    // R2
    claim_free_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_i && !held_o[p0_idx_i]) |=>
            (p0_rdata_o == DATA_W'(1)) && held_o[$past(p0_idx_i)]);

    // R3
    claim_held_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_i && held_o[p0_idx_i] && !p0_wr_i && !(p1_wr_i && same_idx)) |=>
            (p0_rdata_o == '0) && held_o[$past(p0_idx_i)]);

    // R4
    release_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_wr_i && !p0_rd_i && !(p1_rd_i && same_idx)) |=>
            !held_o[$past(p0_idx_i)]);

    // R5
    tie_p1_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_rd_i && p1_rd_i && same_idx) |=> (p1_rdata_o == '0));

    // R7
    free_then_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_wr_i && p1_rd_i && same_idx && !p0_rd_i) |=>
            (p1_rdata_o == DATA_W'(1)));

    // R9
    no_read_zero_p0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p0_rd_i |=> (p0_rdata_o == '0));

    // R9
    no_read_zero_p1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p1_rd_i |=> (p1_rdata_o == '0));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p0_rd_i && !p0_wr_i && !p1_rd_i && !p1_wr_i) |=> $stable(held_o));

endmodule

bind spin_lock_bank spin_lock_bank_chk #(
    .NUM_LOCKS(NUM_LOCKS),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .p0_rd_i    (p0_rd_i),
    .p0_wr_i    (p0_wr_i),
    .p0_idx_i   (p0_idx_i),
    .p0_rdata_o (p0_rdata_o),
    .p1_rd_i    (p1_rd_i),
    .p1_wr_i    (p1_wr_i),
    .p1_idx_i   (p1_idx_i),
    .p1_rdata_o (p1_rdata_o),
    .held_o     (held_o)
);

// File: tb/spin_lock_bank_tb.sv
`timescale 1ns/1ps
module spin_lock_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        p0_rd, p0_wr, p1_rd, p1_wr;
    logic [4:0]  p0_idx, p1_idx;
    logic [31:0] p0_rdata, p1_rdata, held;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_held = '0;

    always #2.5 clk = ~clk;

    spin_lock_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .p0_rd_i(p0_rd), .p0_wr_i(p0_wr), .p0_idx_i(p0_idx), .p0_rdata_o(p0_rdata),
        .p1_rd_i(p1_rd), .p1_wr_i(p1_wr), .p1_idx_i(p1_idx), .p1_rdata_o(p1_rdata),
        .held_o(held)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus checked against a sequential behavioural model.
    task automatic cyc(input logic r0, input logic w0, input logic [4:0] i0,
                       input logic r1, input logic w1, input logic [4:0] i1,
                       input string tag);
        logic [31:0] s;
        logic e0, e1;
        p0_rd = r0; p0_wr = w0; p0_idx = i0;
        p1_rd = r1; p1_wr = w1; p1_idx = i1;
        s = m_held;
        if (w0) s[i0] = 1'b0;
        if (w1) s[i1] = 1'b0;
        e0 = r0 && !s[i0];
        if (e0) s[i0] = 1'b1;
        e1 = r1 && !s[i1];
        if (e1) s[i1] = 1'b1;
        @(posedge clk);
        m_held = s;
        @(negedge clk);
        check(tag, "p0_rdata", p0_rdata, {31'b0, e0});
        check(tag, "p1_rdata", p1_rdata, {31'b0, e1});
        check({tag, "/R8"}, "held", held, m_held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        p0_rd = 0; p0_wr = 0; p0_idx = 0;
        p1_rd = 0; p1_wr = 0; p1_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "held", held, 32'h0);
        check("R1", "p0_rdata", p0_rdata, 32'h0);
        check("R1", "p1_rdata", p1_rdata, 32'h0);

        cyc(1, 0, 5'd3, 0, 0, 5'd0, "R2");   // claim free lock 3
        cyc(1, 0, 5'd3, 0, 0, 5'd0, "R3");   // repeat claim fails
        cyc(0, 0, 5'd0, 1, 0, 5'd3, "R3");   // other port fails too
        cyc(0, 0, 5'd0, 0, 0, 5'd0, "R9");   // idle: data back to zero
        cyc(0, 0, 5'd0, 0, 1, 5'd3, "R4");   // port 1 releases lock 3
        cyc(0, 1, 5'd7, 0, 0, 5'd0, "R4");   // release of a free lock
        cyc(1, 0, 5'd3, 0, 0, 5'd0, "R2");   // reclaim succeeds
        cyc(1, 0, 5'd9, 1, 0, 5'd9, "R5");   // tie: port 0 wins
        cyc(1, 0, 5'd10, 1, 0, 5'd11, "R6"); // distinct locks both win
        cyc(1, 0, 5'd9, 0, 1, 5'd9, "R7");   // p1 frees, p0 claims
        cyc(0, 1, 5'd9, 1, 0, 5'd9, "R7");   // p0 frees, p1 claims
        cyc(0, 0, 5'd0, 1, 1, 5'd9, "R7");   // same port frees and claims
        cyc(1, 0, 5'd0, 1, 0, 5'd31, "R10"); // boundary indices
        cyc(0, 1, 5'd31, 0, 0, 5'd0, "R10");
        cyc(0, 0, 5'd0, 0, 0, 5'd0, "R9");

        for (int k = 0; k < 400; k++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 1), 5'($urandom_range(0, 3)),
                $urandom_range(0, 1), $urandom_range(0, 1), 5'($urandom_range(0, 3)),
                "R10");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule